// File: doc/BRIEF.md
# Accumulator and Carry Register-Reference Unit

This unit executes the register-reference class of a small accumulator machine. Each operation acts only on a 16-bit accumulator and a one-bit carry. The controller presents a 12-bit operation field, the current accumulator and the current carry, together with a valid strobe. One clock edge later the unit returns the updated accumulator and carry as registered outputs. It also returns a one-cycle skip request, which the fetch logic uses to step over the next instruction, and a one-cycle halt request, which clears the machine's run latch.

Exactly one bit of the operation field selects the operation. Four operations touch only the data: clear, invert, rotate through carry, and increment. Four more only test a condition and request a skip: sign positive, sign negative, accumulator zero, and carry zero. One operation requests a halt. A field with no bit set, or with more than one bit set, does nothing.

Top module: `rru_unit`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), and in the first cycle after it is released, `res_acc` is 0, `res_carry` is 0, and `res_valid`, `skip_req` and `halt_req` are 0.
- R2: Field bit 11 (0x800) makes the result accumulator 0. Field bit 10 (0x400) makes the result carry 0. The other register is passed through unchanged.
- R3: Field bit 9 (0x200) inverts every accumulator bit. Field bit 8 (0x100) inverts the carry. The other register is passed through unchanged.
- R4: Field bit 7 (0x080) rotates {carry, acc} right by one place. The old carry goes into acc bit 15 and the old acc bit 0 goes into the carry.
- R5: Field bit 6 (0x040) rotates {carry, acc} left by one place. The old acc bit 15 goes into the carry and the old carry goes into acc bit 0.
- R6: Field bit 5 (0x020) adds one to the accumulator modulo 2^16, so 0xFFFF becomes 0x0000. The carry is left unchanged.
- R7: Field bit 4 (0x010) requests a skip when acc bit 15 is 0. Field bit 3 (0x008) requests a skip when acc bit 15 is 1. Both leave acc and carry unchanged.
- R8: Field bit 2 (0x004) requests a skip when acc is 0x0000. Field bit 1 (0x002) requests a skip when the carry is 0. Both leave acc and carry unchanged.
- R9: Field bit 0 (0x001) raises `halt_req` for one cycle and leaves acc and carry unchanged.
- R10: A valid field with zero bits set or with two or more bits set passes acc and carry through unchanged and raises neither skip nor halt.
- R11: Results, `skip_req` and `halt_req` appear on the first clock edge after `op_valid` is sampled high, and `res_valid` is high in that same cycle. In a cycle where `op_valid` was low, `res_valid`, `skip_req` and `halt_req` are 0 and `res_acc` and `res_carry` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation field and operands are valid this cycle |
| op_field | input | 12 | One-hot operation selector |
| acc_in | input | 16 | Current accumulator value |
| carry_in | input | 1 | Current carry value |
| res_valid | output | 1 | Registered results are from an executed operation |
| res_acc | output | 16 | Registered next accumulator |
| res_carry | output | 1 | Registered next carry |
| skip_req | output | 1 | One-cycle skip request |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The assertions assume that `acc_in`, `carry_in` and `op_field` are free of X and are stable around the sampling edge whenever `op_valid` is high. They also assume that a result is judged only against the operands given with the same strobe. The stimulus changes every input only on the falling clock edge. It draws operands from `$urandom` with a fixed seed, and it draws fields half from single-bit selectors and half from raw 12-bit values, so that zero-bit and multi-bit fields occur. Directed cases cover 0xFFFF, 0x0000, 0x8000, 0x7FFF and both carry values.

// File: rtl/rru_pkg.sv
package rru_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FIELD_W = 12;
  localparam int unsigned SIGN_B  = DATA_W - 1;

  // selector bit positions, decoded by the controller
  localparam int unsigned B_HALT  = 0;
  localparam int unsigned B_SKCZ  = 1;
  localparam int unsigned B_SKZ   = 2;
  localparam int unsigned B_SKNEG = 3;
  localparam int unsigned B_SKPOS = 4;
  localparam int unsigned B_INC   = 5;
  localparam int unsigned B_ROTL  = 6;
  localparam int unsigned B_ROTR  = 7;
  localparam int unsigned B_INVC  = 8;
  localparam int unsigned B_INVA  = 9;
  localparam int unsigned B_CLRC  = 10;
  localparam int unsigned B_CLRA  = 11;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    word_t acc;
    logic  cy;
  } regpair_t;

  function automatic int unsigned bit_count(input field_t f);
    int unsigned n;
    n = 0;
    for (int i = 0; i < FIELD_W; i++) n += int'(f[i]);
    return n;
  endfunction

  function automatic regpair_t rot_right(input word_t a, input logic c);
    regpair_t r;
    r.acc = {c, a[DATA_W-1:1]};
    r.cy  = a[0];
    return r;
  endfunction

  function automatic regpair_t rot_left(input word_t a, input logic c);
    regpair_t r;
    r.acc = {a[DATA_W-2:0], c};
    r.cy  = a[SIGN_B];
    return r;
  endfunction

  // data effect of a single selector bit; test/halt bits pass through
  function automatic regpair_t apply_bit(input int unsigned b, input word_t a, input logic c);
    regpair_t r;
    r.acc = a;
    r.cy  = c;
    case (b)
      B_CLRA: r.acc = '0;
      B_CLRC: r.cy  = 1'b0;
      B_INVA: r.acc = ~a;
      B_INVC: r.cy  = ~c;
      B_ROTR: r = rot_right(a, c);
      B_ROTL: r = rot_left(a, c);
      B_INC:  r.acc = a + word_t'(1);
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rru_decode.sv
module rru_decode
  import rru_pkg::*;
(
  input  logic   op_valid,
  input  field_t op_field,
  output logic   legal,
  output field_t sel
);
  logic single_hot;

  always_comb begin
    single_hot = (bit_count(op_field) == 1);
    legal      = op_valid && single_hot;
    sel        = legal ? op_field : '0;
  end

  always_comb begin
    if (legal) a_sel_single_r10: assert ($onehot(sel));
    if (!op_valid) a_sel_idle_r11: assert (sel == '0);
  end
endmodule

// File: rtl/rru_datapath.sv
module rru_datapath
  import rru_pkg::*;
(
  input  field_t   sel,
  input  word_t    acc_in,
  input  logic     carry_in,
  output regpair_t nxt
);
  regpair_t cand [FIELD_W];

  generate
    for (genvar g = 0; g < FIELD_W; g++) begin : g_cand
      assign cand[g] = apply_bit(g, acc_in, carry_in);
    end
  endgenerate

  always_comb begin
    nxt.acc = acc_in;
    nxt.cy  = carry_in;
    for (int i = 0; i < FIELD_W; i++) begin
      if (sel[i]) nxt = cand[i];
    end
  end

  always_comb begin
    if (sel[B_INC] && acc_in == '1) a_inc_wrap_r6: assert (nxt.acc == '0 && nxt.cy == carry_in);
    if (sel[B_CLRA]) a_clra_r2: assert (nxt.acc == '0 && nxt.cy == carry_in);
    if (sel == '0) a_pass_r10: assert (nxt.acc == acc_in && nxt.cy == carry_in);
  end
endmodule

// File: rtl/rru_cond.sv
module rru_cond
  import rru_pkg::*;
(
  input  field_t sel,
  input  word_t  acc_in,
  input  logic   carry_in,
  output logic   skip,
  output logic   halt
);
  logic is_pos, is_neg, is_zero, cy_zero;

  always_comb begin
    is_pos  = ~acc_in[SIGN_B];
    is_neg  =  acc_in[SIGN_B];
    is_zero = (acc_in == '0);
    cy_zero = ~carry_in;
    skip    = (sel[B_SKPOS] & is_pos) | (sel[B_SKNEG] & is_neg)
            | (sel[B_SKZ]   & is_zero) | (sel[B_SKCZ] & cy_zero);
    halt    = sel[B_HALT];
  end

  always_comb begin
    if (skip && sel[B_SKPOS]) a_skpos_r7: assert (acc_in[SIGN_B] == 1'b0);
    if (skip && sel[B_SKNEG]) a_skneg_r7: assert (acc_in[SIGN_B] == 1'b1);
    if (skip && sel[B_SKZ])   a_skz_r8: assert (acc_in == '0);
    if (skip && sel[B_SKCZ])  a_skcz_r8: assert (carry_in == 1'b0);
  end
endmodule

// File: rtl/rru_unit.sv
module rru_unit
  import rru_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [11:0] op_field,
  input  logic [15:0] acc_in,
  input  logic        carry_in,
  output logic        res_valid,
  output logic [15:0] res_acc,
  output logic        res_carry,
  output logic        skip_req,
  output logic        halt_req
);
  logic     legal;
  field_t   sel;
  regpair_t nxt;
  logic     skip_c, halt_c;

  rru_decode u_decode (
    .op_valid (op_valid),
    .op_field (op_field),
    .legal    (legal),
    .sel      (sel)
  );

  rru_datapath u_datapath (
    .sel      (sel),
    .acc_in   (acc_in),
    .carry_in (carry_in),
    .nxt      (nxt)
  );

  rru_cond u_cond (
    .sel      (sel),
    .acc_in   (acc_in),
    .carry_in (carry_in),
    .skip     (skip_c),
    .halt     (halt_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_acc   <= '0;
      res_carry <= 1'b0;
      skip_req  <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      skip_req  <= op_valid & skip_c;
      halt_req  <= op_valid & halt_c;
      if (op_valid) begin
        res_acc   <= nxt.acc;
        res_carry <= nxt.cy;
      end
    end
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !skip_req && !halt_req));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_acc) && $stable(res_carry)));
  p_halt_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_field == 12'h001) |=> (halt_req && res_acc == $past(acc_in) && res_carry == $past(carry_in)));
  p_illegal_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !legal) |=> (!skip_req && !halt_req && res_acc == $past(acc_in)));
  p_skip_halt_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_req && halt_req));
endmodule

// File: tb/test_rru_unit.sv
module test_rru_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [11:0] op_field = '0;
  logic [15:0] acc_in = '0;
  logic        carry_in = 1'b0;
  logic        res_valid, res_carry, skip_req, halt_req;
  logic [15:0] res_acc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rru_unit i_rru_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_field(op_field),
    .acc_in(acc_in), .carry_in(carry_in), .res_valid(res_valid),
    .res_acc(res_acc), .res_carry(res_carry), .skip_req(skip_req), .halt_req(halt_req)
  );

  // reference: returns {acc, carry, skip, halt}
  function automatic logic [18:0] model(input logic [11:0] f, input logic [15:0] a, input logic c);
    logic [15:0] na = a; logic nc = c; logic sk = 0; logic h = 0;
    case (f)
      12'h800: na = 16'h0000;
      12'h400: nc = 1'b0;
      12'h200: na = a ^ 16'hFFFF;
      12'h100: nc = !c;
      12'h080: begin na = (a >> 1) | (c ? 16'h8000 : 16'h0); nc = a[0]; end
      12'h040: begin na = (a << 1) | {15'd0, c}; nc = a[15]; end
      12'h020: na = 16'((32'(a) + 1) % 65536);
      12'h010: sk = (a < 16'h8000);
      12'h008: sk = (a >= 16'h8000);
      12'h004: sk = (a == 0);
      12'h002: sk = (c == 0);
      12'h001: h = 1;
      default: ;
    endcase
    return {na, nc, sk, h};
  endfunction

  function automatic string tag(input logic [11:0] f);
    case (f)
      12'h800, 12'h400: return "R2";
      12'h200, 12'h100: return "R3";
      12'h080: return "R4";
      12'h040: return "R5";
      12'h020: return "R6";
      12'h010, 12'h008: return "R7";
      12'h004, 12'h002: return "R8";
      12'h001: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [11:0] f, input logic [15:0] a, input logic c);
    logic [18:0] e;
    e = model(f, a, c);
    @(negedge clk);
    op_valid = 1; op_field = f; acc_in = a; carry_in = c;
    @(negedge clk);
    op_valid = 0;
    check(tag(f), {res_acc, res_carry, skip_req, halt_req}, e);
    checks++;
    if (res_valid !== 1'b1) begin fails++; $display("FAIL R11 res_valid got=%b exp=1", res_valid); end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] f;
    logic [15:0] held;
    logic        heldc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", {res_acc, res_carry, skip_req, halt_req}, 19'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", {res_acc, res_carry, res_valid, halt_req}, 19'd0);

    // directed corners
    run_op(12'h020, 16'hFFFF, 1'b1);   // R6 wrap
    run_op(12'h080, 16'h0001, 1'b0);   // R4
    run_op(12'h080, 16'h8000, 1'b1);   // R4
    run_op(12'h040, 16'h8000, 1'b0);   // R5
    run_op(12'h040, 16'h7FFF, 1'b1);   // R5
    run_op(12'h010, 16'h7FFF, 1'b0);   // R7
    run_op(12'h010, 16'h8000, 1'b0);   // R7
    run_op(12'h008, 16'h8000, 1'b1);   // R7
    run_op(12'h004, 16'h0000, 1'b1);   // R8
    run_op(12'h004, 16'h0001, 1'b1);   // R8
    run_op(12'h002, 16'h1234, 1'b0);   // R8
    run_op(12'h002, 16'h1234, 1'b1);   // R8
    run_op(12'h001, 16'hBEEF, 1'b1);   // R9
    run_op(12'h800, 16'hFFFF, 1'b1);   // R2
    run_op(12'h400, 16'h5555, 1'b1);   // R2
    run_op(12'h200, 16'h0F0F, 1'b0);   // R3
    run_op(12'h100, 16'h0F0F, 1'b0);   // R3
    run_op(12'h000, 16'hA5A5, 1'b1);   // R10 empty
    run_op(12'h003, 16'h0000, 1'b0);   // R10 multi
    run_op(12'h820, 16'h1111, 1'b1);   // R10 multi

    // R11: idle cycles hold results and stay quiet
    held = res_acc; heldc = res_carry;
    @(negedge clk);
    acc_in = 16'h9999; carry_in = ~heldc; op_field = 12'h800;
    @(negedge clk);
    check("R11", {res_acc, res_carry, res_valid, skip_req}, {held, heldc, 2'b00});

    // constrained random
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(1, 0) == 1) f = 12'h001 << $urandom_range(11, 0);
      else f = 12'($urandom);
      run_op(f, 16'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule